// File: doc/BRIEF.md
# Banked Memory Block Copier

This block copies a run of bytes from one 64 KiB bank of a 24-bit address space to another. Software-visible state is modelled as three 16-bit registers: a source offset, a destination offset, and a count that holds the number of bytes minus one. There are also two 8-bit bank numbers. A start strobe carries an 8-bit operation code that selects whether the offsets climb or fall as the copy proceeds. A code that names neither direction is dropped.

Each byte uses two requests on a single-port memory interface. The engine first reads the byte from the source address, then writes it to the destination address. Each request is held until the memory raises its ready line. After every write the offsets step by one in the chosen direction and the count steps down by one. The copy ends after the byte on which the count falls through zero. The engine then pulses a completion flag while presenting the final offsets, the exhausted count and a data bank value equal to the destination bank.

The falling direction is meant for overlapping moves where the destination lies above the source; the climbing direction covers every other case. Offsets wrap inside their bank and never carry into the bank byte.

Top module: `bkmove_engine`

## Requirements
- R1: After reset, busy, done and mem_req are low, and x_out, y_out, c_out and dbank_out are zero.
- R2: Every byte is one read (mem_we low) at address {source bank, X} followed by one write (mem_we high) at address {destination bank, Y}. The write data equals the data returned by that read.
- R3: Operation code 0x54 makes X and Y increase by one after each byte, and operation code 0x44 makes them decrease by one.
- R4: Exactly len_m1+1 bytes are copied.
- R5: Offsets wrap modulo 2^16 (0xFFFF+1 gives 0x0000, and 0x0000-1 gives 0xFFFF). mem_addr[23:16] stays at the latched bank for the whole move.
- R6: When done is high, x_out and y_out equal their start values moved by len_m1+1 in the chosen direction, c_out is 0xFFFF, and dbank_out equals the destination bank.
- R7: While mem_req is high and mem_rdy is low, mem_addr, mem_we and mem_wdata hold their values into the next cycle. A phase advances only on an edge where mem_rdy is high.
- R8: done is high for exactly one cycle, in the cycle after the final write is accepted. busy is high from the cycle after an accepted start through the done cycle, and low after it.
- R9: A start strobe while busy is high has no effect on the running copy.
- R10: A start strobe whose op_code is neither 0x54 nor 0x44 is ignored: busy and mem_req stay low, and x_out keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch strobe, sampled when idle |
| op_code | input | 8 | Direction code: 0x54 climbing, 0x44 falling |
| src_ofs | input | 16 | Starting source offset (X) |
| dst_ofs | input | 16 | Starting destination offset (Y) |
| len_m1 | input | 16 | Byte count minus one (C) |
| src_bank | input | 8 | Source bank byte |
| dst_bank | input | 8 | Destination bank byte |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | High for write, low for read |
| mem_addr | output | 24 | {bank, offset} address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid with mem_rdy on a read |
| mem_rdy | input | 1 | Memory accepts the current request |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle completion pulse |
| x_out | output | 16 | Current or final source offset |
| y_out | output | 16 | Current or final destination offset |
| c_out | output | 16 | Current or final count |
| dbank_out | output | 8 | Data bank, set to the destination bank at completion |

## Verification
The checker keeps its own copy of the bank bytes, taken on every start strobe that arrives while busy is low with a legal code. It therefore assumes that the bank inputs are stable on that edge. It also assumes that mem_rdata is valid on the edge where a read is accepted. The bench returns read data as a pure function of the address it is given, and holds every launch input steady for the whole strobe cycle. Ready is withheld at random so that the hold rules see long and short stalls. Lengths are kept to a few dozen bytes so that many starts, wraps at both ends of a bank and both directions fit the run.

// File: rtl/bkmove_pkg.sv
`timescale 1ns/1ps
package bkmove_pkg;

   localparam logic [7:0] OP_CLIMB = 8'h54;
   localparam logic [7:0] OP_FALL  = 8'h44;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RD   = 2'd1,
      ST_WR   = 2'd2,
      ST_FIN  = 2'd3
   } mv_state_t;

endpackage

// File: rtl/bkmove_decode.sv
`timescale 1ns/1ps
module bkmove_decode
   import bkmove_pkg::*;
(
   input  logic [7:0] op_code,
   output logic       op_ok,
   output logic       op_fall
);
   // the two legal codes differ only in bit 4; full compare rejects the rest
   always_comb begin
      op_ok   = (op_code == OP_CLIMB) || (op_code == OP_FALL);
      op_fall = (op_code == OP_FALL);
   end
endmodule

// File: rtl/bkmove_ofs_step.sv
`timescale 1ns/1ps
module bkmove_ofs_step #(
   parameter int OFS_W  = 16,
   parameter bit SHARED = 1'b1
) (
   input  logic [OFS_W-1:0] cur,
   input  logic             fall,
   output logic [OFS_W-1:0] nxt
);
   localparam logic [OFS_W-1:0] ONE    = OFS_W'(1);
   localparam logic [OFS_W-1:0] MINUS1 = {OFS_W{1'b1}};

   generate
      if (SHARED) begin : g_shared
         // one adder, operand chooses +1 or -1 (two's complement)
         always_comb nxt = cur + (fall ? MINUS1 : ONE);
      end else begin : g_split
         logic [OFS_W-1:0] up_v;
         logic [OFS_W-1:0] dn_v;
         always_comb begin
            up_v = cur + ONE;
            dn_v = cur - ONE;
            nxt  = fall ? dn_v : up_v;
         end
      end
   endgenerate
endmodule

// File: rtl/bkmove_ctrl.sv
`timescale 1ns/1ps
module bkmove_ctrl
   import bkmove_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      launch,
   input  logic      mem_rdy,
   input  logic      last_byte,
   output mv_state_t state,
   output logic      rd_take,
   output logic      wr_take
);
   mv_state_t state_q, state_d;

   always_comb begin
      rd_take = (state_q == ST_RD) && mem_rdy;
      wr_take = (state_q == ST_WR) && mem_rdy;
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (launch)  state_d = ST_RD;
         ST_RD:   if (rd_take) state_d = ST_WR;
         ST_WR:   if (wr_take) state_d = last_byte ? ST_FIN : ST_RD;
         ST_FIN:               state_d = ST_IDLE;
         default:              state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign state = state_q;
endmodule

// File: rtl/bkmove_engine.sv
`timescale 1ns/1ps
module bkmove_engine
   import bkmove_pkg::*;
#(
   parameter int OFS_W      = 16,
   parameter int BANK_W     = 8,
   parameter int DATA_W     = 8,
   parameter bit SHARED_ADD = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic [7:0]               op_code,
   input  logic [OFS_W-1:0]         src_ofs,
   input  logic [OFS_W-1:0]         dst_ofs,
   input  logic [OFS_W-1:0]         len_m1,
   input  logic [BANK_W-1:0]        src_bank,
   input  logic [BANK_W-1:0]        dst_bank,
   output logic                     mem_req,
   output logic                     mem_we,
   output logic [BANK_W+OFS_W-1:0]  mem_addr,
   output logic [DATA_W-1:0]        mem_wdata,
   input  logic [DATA_W-1:0]        mem_rdata,
   input  logic                     mem_rdy,
   output logic                     busy,
   output logic                     done,
   output logic [OFS_W-1:0]         x_out,
   output logic [OFS_W-1:0]         y_out,
   output logic [OFS_W-1:0]         c_out,
   output logic [BANK_W-1:0]        dbank_out
);
   localparam int ADDR_W = BANK_W + OFS_W;

   generate
      if (OFS_W < 2) begin : g_bad_ofs
         initial $fatal(1, "bkmove_engine: OFS_W must be at least 2");
      end
      if (BANK_W < 1) begin : g_bad_bank
         initial $fatal(1, "bkmove_engine: BANK_W must be at least 1");
      end
      if (DATA_W < 1) begin : g_bad_data
         initial $fatal(1, "bkmove_engine: DATA_W must be at least 1");
      end
   endgenerate

   logic              op_ok, op_fall, launch;
   logic              rd_take, wr_take, last_byte;
   mv_state_t         state;
   logic [OFS_W-1:0]  x_q, y_q, c_q, x_nxt, y_nxt;
   logic [BANK_W-1:0] sb_q, db_q, dbank_q;
   logic [DATA_W-1:0] hold_q;
   logic              fall_q;

   bkmove_decode u_dec (
      .op_code (op_code),
      .op_ok   (op_ok),
      .op_fall (op_fall)
   );

   assign launch    = start && op_ok && (state == ST_IDLE);
   // the count wraps through zero on the final byte
   assign last_byte = (c_q == '0);

   bkmove_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .launch    (launch),
      .mem_rdy   (mem_rdy),
      .last_byte (last_byte),
      .state     (state),
      .rd_take   (rd_take),
      .wr_take   (wr_take)
   );

   bkmove_ofs_step #(.OFS_W(OFS_W), .SHARED(SHARED_ADD)) u_xstep (
      .cur  (x_q),
      .fall (fall_q),
      .nxt  (x_nxt)
   );

   bkmove_ofs_step #(.OFS_W(OFS_W), .SHARED(SHARED_ADD)) u_ystep (
      .cur  (y_q),
      .fall (fall_q),
      .nxt  (y_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x_q     <= '0;
         y_q     <= '0;
         c_q     <= '0;
         sb_q    <= '0;
         db_q    <= '0;
         dbank_q <= '0;
         hold_q  <= '0;
         fall_q  <= 1'b0;
      end else begin
         if (launch) begin
            x_q    <= src_ofs;
            y_q    <= dst_ofs;
            c_q    <= len_m1;
            sb_q   <= src_bank;
            db_q   <= dst_bank;
            fall_q <= op_fall;
         end
         if (rd_take) hold_q <= mem_rdata;
         if (wr_take) begin
            x_q <= x_nxt;
            y_q <= y_nxt;
            c_q <= c_q - OFS_W'(1);
            if (last_byte) dbank_q <= db_q;
         end
      end
   end

   always_comb begin
      mem_req   = (state == ST_RD) || (state == ST_WR);
      mem_we    = (state == ST_WR);
      mem_addr  = (state == ST_WR) ? ADDR_W'({db_q, y_q}) : ADDR_W'({sb_q, x_q});
      mem_wdata = hold_q;
      busy      = (state != ST_IDLE);
      done      = (state == ST_FIN);
   end

   assign x_out     = x_q;
   assign y_out     = y_q;
   assign c_out     = c_q;
   assign dbank_out = dbank_q;
endmodule

// File: rtl/bkmove_chk.sv
`timescale 1ns/1ps
module bkmove_chk
   import bkmove_pkg::*;
#(
   parameter int OFS_W  = 16,
   parameter int BANK_W = 8,
   parameter int DATA_W = 8
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    start,
   input logic [7:0]              op_code,
   input logic [BANK_W-1:0]       src_bank,
   input logic [BANK_W-1:0]       dst_bank,
   input logic                    mem_req,
   input logic                    mem_we,
   input logic [BANK_W+OFS_W-1:0] mem_addr,
   input logic [DATA_W-1:0]       mem_wdata,
   input logic                    mem_rdy,
   input logic                    busy,
   input logic                    done,
   input logic [OFS_W-1:0]        c_out,
   input logic [BANK_W-1:0]       dbank_out
);
   logic [BANK_W-1:0] cap_sb, cap_db;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_sb <= '0;
         cap_db <= '0;
      end else if (start && !busy && (op_code == OP_CLIMB || op_code == OP_FALL)) begin
         cap_sb <= src_bank;
         cap_db <= dst_bank;
      end
   end

   // R7
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

   // R2
   rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we && mem_rdy) |=> (mem_req && mem_we));

   // R5
   bank_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[BANK_W+OFS_W-1:OFS_W] == (mem_we ? cap_db : cap_sb)));

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));

   // R8
   req_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req || done) |-> busy);

   // R6
   fin_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (c_out == {OFS_W{1'b1}} && dbank_out == cap_db && !mem_req));
endmodule

bind bkmove_engine bkmove_chk #(.OFS_W(OFS_W), .BANK_W(BANK_W), .DATA_W(DATA_W)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .op_code   (op_code),
   .src_bank  (src_bank),
   .dst_bank  (dst_bank),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .mem_rdy   (mem_rdy),
   .busy      (busy),
   .done      (done),
   .c_out     (c_out),
   .dbank_out (dbank_out)
);

// File: tb/test_bkmove_engine.sv
`timescale 1ns/1ps
module test_bkmove_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  op_code = 8'h00;
   logic [15:0] src_ofs = '0, dst_ofs = '0, len_m1 = '0;
   logic [7:0]  src_bank = '0, dst_bank = '0;
   logic        mem_req, mem_we, mem_rdy = 1'b1;
   logic [23:0] mem_addr;
   logic [7:0]  mem_wdata, mem_rdata;
   logic        busy, done;
   logic [15:0] x_out, y_out, c_out;
   logic [7:0]  dbank_out;

   int total = 0, bad = 0, cyc = 0;
   bit rdy_rand = 1'b1;

   // expectation of the monitored move
   logic [15:0] t_sx, t_dy;
   logic [7:0]  t_sb, t_db, rd_val;
   bit          t_fall;
   int          k = 0, seq_err = 0, stall_err = 0;
   bit          phase = 1'b0, stall_prev = 1'b0;
   logic [23:0] p_addr;
   logic        p_we;
   logic [7:0]  p_wd;

   always #2.5 clk = ~clk;

   bkmove_engine i_bkmove_engine (
      .clk(clk), .rst_n(rst_n), .start(start), .op_code(op_code),
      .src_ofs(src_ofs), .dst_ofs(dst_ofs), .len_m1(len_m1),
      .src_bank(src_bank), .dst_bank(dst_bank),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rdy(mem_rdy),
      .busy(busy), .done(done), .x_out(x_out), .y_out(y_out),
      .c_out(c_out), .dbank_out(dbank_out)
   );

   function automatic logic [7:0] mem_fn(input logic [23:0] a);
      return a[7:0] ^ {a[12:8], a[15:13]} ^ {a[20:16], a[23:21]} ^ 8'h5A;
   endfunction

   function automatic logic [15:0] step_ofs(input logic [15:0] s, input bit fall, input int n);
      return fall ? 16'(s - 16'(n)) : 16'(s + 16'(n));
   endfunction

   assign mem_rdata = mem_fn(mem_addr);

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000) begin
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   // memory model and transfer monitor
   always @(negedge clk) begin
      mem_rdy = rdy_rand ? (($urandom % 3) != 0) : 1'b1;
      if (mem_req) begin
         if (stall_prev && (mem_addr != p_addr || mem_we != p_we || mem_wdata != p_wd))
            stall_err++;
         if (mem_rdy) begin
            if (!mem_we) begin
               if (phase != 1'b0 || mem_addr != {t_sb, step_ofs(t_sx, t_fall, k)}) seq_err++;
               rd_val = mem_fn(mem_addr);
               phase = 1'b1;
            end else begin
               if (phase != 1'b1 || mem_addr != {t_db, step_ofs(t_dy, t_fall, k)} || mem_wdata != rd_val)
                  seq_err++;
               phase = 1'b0;
               k++;
            end
         end
         stall_prev = !mem_rdy;
         p_addr = mem_addr; p_we = mem_we; p_wd = mem_wdata;
      end else begin
         stall_prev = 1'b0;
      end
   end

   task automatic run_move(input logic [7:0] op, input logic [15:0] sx, input logic [15:0] dy,
                           input logic [15:0] ln, input logic [7:0] sb, input logic [7:0] db,
                           input bit poke);
      int n;
      bit seen;
      t_sx = sx; t_dy = dy; t_sb = sb; t_db = db; t_fall = (op == 8'h44);
      k = 0; seq_err = 0; stall_err = 0; phase = 1'b0;
      op_code = op; src_ofs = sx; dst_ofs = dy; len_m1 = ln;
      src_bank = sb; dst_bank = db; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      // R8 busy follows an accepted start
      chk(busy == 1'b1, "R8 busy after start", 32'(busy), 32'd1);
      seen = 1'b0;
      for (int i = 0; i < 8000 && !seen; i++) begin
         if (poke && i == 3) begin
            // R9 second strobe mid-move
            op_code = 8'h54; src_ofs = 16'h1111; dst_ofs = 16'h2222; len_m1 = 16'h0003;
            src_bank = 8'hEE; dst_bank = 8'hDD; start = 1'b1;
         end else begin
            start = 1'b0;
         end
         if (done) seen = 1'b1;
         else @(negedge clk);
      end
      start = 1'b0;
      chk(seen, "R8 done reached", 32'(seen), 32'd1);
      n = int'(ln) + 1;
      chk(seq_err == 0, "R2 R3 R5 byte order and addresses", 32'(seq_err), 32'd0);
      chk(k == n, "R4 byte count", 32'(k), 32'(n));
      chk(stall_err == 0, "R7 request held during stall", 32'(stall_err), 32'd0);
      chk(x_out == step_ofs(sx, t_fall, n), "R6 final x", 32'(x_out), 32'(step_ofs(sx, t_fall, n)));
      chk(y_out == step_ofs(dy, t_fall, n), "R6 final y", 32'(y_out), 32'(step_ofs(dy, t_fall, n)));
      chk(c_out == 16'hFFFF && dbank_out == db, "R6 final count and bank",
          {8'h0, dbank_out, c_out}, {8'h0, db, 16'hFFFF});
      @(negedge clk);
      chk(!done && !busy, "R8 done one cycle", {30'd0, done, busy}, 32'd0);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!busy && !done && !mem_req, "R1 reset control", {29'd0, busy, done, mem_req}, 32'd0);
      chk(x_out == 0 && y_out == 0 && c_out == 0 && dbank_out == 0, "R1 reset registers",
          32'(x_out | y_out | c_out | 16'(dbank_out)), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R10 illegal code ignored
      op_code = 8'h45; src_ofs = 16'h4321; len_m1 = 16'h0002; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(!busy && !mem_req && x_out == 16'h0000, "R10 bad code ignored",
          {14'd0, busy, mem_req, x_out}, 32'd0);

      // directed corners
      rdy_rand = 1'b0;
      run_move(8'h54, 16'h0100, 16'h0200, 16'h0000, 8'h01, 8'h02, 1'b0); // R4 single byte
      rdy_rand = 1'b1;
      run_move(8'h54, 16'hFFFE, 16'hFFFD, 16'h0004, 8'h7E, 8'h7F, 1'b0); // R5 climb wrap
      run_move(8'h44, 16'h0001, 16'h0002, 16'h0004, 8'h10, 8'h20, 1'b0); // R5 fall wrap
      run_move(8'h44, 16'h3010, 16'h3014, 16'h000F, 8'h33, 8'h33, 1'b1); // R3 R9 overlap, strobe
      run_move(8'h54, 16'h8000, 16'h9000, 16'h0007, 8'hFF, 8'h00, 1'b1); // R9 climb with strobe

      // R10 after a move: x_out must hold its value
      op_code = 8'h00; src_ofs = 16'hABCD; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(!busy && x_out == 16'h8008, "R10 x kept", {15'd0, busy, x_out}, 32'h8008);

      for (int r = 0; r < 24; r++) begin
         rdy_rand = (r % 4) != 0;
         run_move(($urandom % 2) ? 8'h44 : 8'h54, 16'($urandom), 16'($urandom),
                  16'($urandom % 40), 8'($urandom), 8'($urandom), (r % 5) == 2);
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule